// File: doc/BRIEF.md
# Serial Register Access Slave with Framing Autodetect

This block is the serial control port of a larger device. A host reaches an internal register file over a four-wire serial bus: an active-low select, a serial clock, a host-to-slave data line and a tri-statable slave-to-host data line. Every access carries three bytes in a fixed sequence. A control byte comes first. Its most significant bit picks read or write. An address byte follows, then a data byte. All bytes are sent most significant bit first. The slave samples input bits on rising serial-clock edges and changes its output bit on falling edges.

The host may frame an access as three bytes, or as four bytes grouped into two 16-bit words. No setting selects the framing. The slave decides from the select line: if the select stays low after the data byte, a fourth byte follows. In a 4-byte write, that fourth byte is thrown away. In a 4-byte read, the read value is sent a second time, so a host that captures only the second half of its second word still gets it. Serial-bus inputs pass through synchronisers into a faster system clock. The register file is reached through a plain parallel port with address, write data, a one-cycle write strobe and combinational read data.

Top module: `spi_regslave`

## Requirements
- R1: Input bits are captured on rising serial-clock edges, most significant bit first, in the order control byte, address byte, data byte.
- R2: Control-byte bit 7 equal to 1 means read and 0 means write; the other seven control bits have no effect.
- R3: A write raises `reg_we` for exactly one system-clock cycle, once per access, after the 24th bit is captured, with `reg_addr` and `reg_wdata` holding the received address and data.
- R4: In a read, the byte on `reg_rdata` for the received address is driven on `spi_miso`, most significant bit first, changing on falling serial-clock edges. The first bit appears on the falling edge that follows the 16th rising edge.
- R5: If the select stays low past the data byte of a read, the same read byte is driven a second time during bits 25 to 32.
- R6: In a write, bits 25 to 32 are discarded and cause no second strobe.
- R7: `frame16` goes to 1 when a 25th bit is captured in a frame. It goes to 0 at the first bit of the next frame, and keeps its value while the select is high.
- R8: Raising the select before the 24th bit cancels the write and resets the bit counter, so the next frame starts at its control byte.
- R9: `spi_miso_oe` is 0 while the select is high, during the control and address bytes, for the whole of any write, and after the 32nd bit.
- R10: Bits past the 32nd within one frame are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Active-low select from the host |
| spi_sclk | input | 1 | Serial clock from the host, idle low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial read data to the host |
| spi_miso_oe | output | 1 | Output enable for `spi_miso`; 0 means tri-stated |
| frame16 | output | 1 | Framing of the latest frame: 1 means 16-bit words |
| reg_addr | output | BYTE_W | Register address of the current access |
| reg_wdata | output | BYTE_W | Register write data |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_rdata | input | BYTE_W | Register read data for `reg_addr`, combinational |

## Verification
Writes and reads go through in 24-bit, 32-bit and 40-bit frames, so one stimulus set covers both framings and bits past the end of a frame. The data values are asymmetric, which exposes a wrong bit order or an off-by-one bit position. Control bytes with all the lower bits set show whether anything but bit 7 decides the direction. A read after a frame cut short at 20 bits shows both that the write was cancelled and that the counter realigned. In a 32-bit read, comparing the first and second copies of the data byte separates the repeat from a plain continued shift.

// File: rtl/spi_regslave_pkg.sv
package spi_regslave_pkg;

   // Longest frame in bytes: control, address, data, trailing byte.
   localparam int unsigned FRAME_BYTES = 4;

   function automatic int unsigned frame_cnt_w(input int unsigned byte_w);
      return $clog2(FRAME_BYTES * byte_w + 1);
   endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic q
);

   initial begin
      assert_stages_min : assert (STAGES >= 2)
         else $error("spi_pin_sync needs at least two stages");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], din};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift #(
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned CNT_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_act,
   input  logic              sck_fall,
   input  logic [CNT_W-1:0]  bit_cnt,
   input  logic              is_read,
   input  logic [BYTE_W-1:0] rdata,
   output logic              sdo,
   output logic              sdo_oe
);

   localparam logic [CNT_W-1:0] LOAD_AT   = CNT_W'(2 * BYTE_W);
   localparam logic [CNT_W-1:0] REPEAT_AT = CNT_W'(3 * BYTE_W);
   localparam logic [CNT_W-1:0] STOP_AT   = CNT_W'(4 * BYTE_W);

   logic [BYTE_W-1:0] sh;
   logic [BYTE_W-1:0] keep;
   logic              drv;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh   <= '0;
         keep <= '0;
         drv  <= 1'b0;
      end else if (!cs_act) begin
         drv <= 1'b0;
      end else if (sck_fall) begin
         if (bit_cnt == LOAD_AT && is_read) begin
            sh   <= rdata;
            keep <= rdata;
            drv  <= 1'b1;
         end else if (bit_cnt == REPEAT_AT && drv) begin
            sh <= keep;
         end else if (bit_cnt == STOP_AT) begin
            drv <= 1'b0;
         end else if (drv) begin
            sh <= {sh[BYTE_W-2:0], 1'b0};
         end
      end
   end

   assign sdo    = drv ? sh[BYTE_W-1] : 1'b0;
   assign sdo_oe = drv & cs_act;

   // R4: driving starts only after the address byte of a read
   assert_oe_start_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drv) |-> (bit_cnt == LOAD_AT) && is_read);

   // R9: select released stops driving on the next cycle
   assert_oe_release_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |=> !sdo_oe);

endmodule

// File: rtl/spi_frame_core.sv
module spi_frame_core #(
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned CNT_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_act,
   input  logic              sclk_s,
   input  logic              sdi_s,
   input  logic [BYTE_W-1:0] rdata,
   output logic [BYTE_W-1:0] addr,
   output logic [BYTE_W-1:0] wdata,
   output logic              we,
   output logic              frame16,
   output logic              sdo,
   output logic              sdo_oe
);

   localparam logic [CNT_W-1:0] CTRL_LAST = CNT_W'(BYTE_W - 1);
   localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(2 * BYTE_W - 1);
   localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(3 * BYTE_W - 1);
   localparam logic [CNT_W-1:0] DATA_DONE = CNT_W'(3 * BYTE_W);
   localparam logic [CNT_W-1:0] FRAME_MAX = CNT_W'(4 * BYTE_W);

   logic              sclk_d;
   logic              sck_rise;
   logic              sck_fall;
   logic [CNT_W-1:0]  bit_cnt;
   logic [BYTE_W-2:0] shin;
   logic [BYTE_W-1:0] cur_byte;
   logic              is_read;

   assign sck_rise = sclk_s & ~sclk_d;
   assign sck_fall = ~sclk_s & sclk_d;
   assign cur_byte = {shin, sdi_s};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d  <= 1'b0;
         bit_cnt <= '0;
         shin    <= '0;
         is_read <= 1'b0;
         addr    <= '0;
         wdata   <= '0;
         we      <= 1'b0;
         frame16 <= 1'b0;
      end else begin
         sclk_d <= sclk_s;
         we     <= 1'b0;
         if (!cs_act) begin
            bit_cnt <= '0;
         end else if (sck_rise && bit_cnt < FRAME_MAX) begin
            shin    <= cur_byte[BYTE_W-2:0];
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == '0)       frame16 <= 1'b0;
            if (bit_cnt == CTRL_LAST) is_read <= cur_byte[BYTE_W-1];
            if (bit_cnt == ADDR_LAST) addr    <= cur_byte;
            if (bit_cnt == DATA_LAST) begin
               wdata <= cur_byte;
               we    <= ~is_read;
            end
            if (bit_cnt == DATA_DONE) frame16 <= 1'b1;
         end
      end
   end

   spi_tx_shift #(
      .BYTE_W (BYTE_W),
      .CNT_W  (CNT_W)
   ) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs_act   (cs_act),
      .sck_fall (sck_fall),
      .bit_cnt  (bit_cnt),
      .is_read  (is_read),
      .rdata    (rdata),
      .sdo      (sdo),
      .sdo_oe   (sdo_oe)
   );

   // R3: strobe only in the cycle the data byte completes
   assert_we_at_data_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      we |-> bit_cnt == DATA_DONE);

   // R3: strobe lasts one cycle
   assert_we_single_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      we |=> !we);

   // R8: releasing select clears the counter
   assert_cnt_clear_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |=> bit_cnt == '0);

   // R7: framing flag rises with the 25th bit
   assert_frame16_set_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frame16) |-> bit_cnt == DATA_DONE + 1'b1);

   // R10: counter never passes the frame limit
   assert_cnt_cap_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt <= FRAME_MAX);

endmodule

// File: rtl/spi_regslave.sv
module spi_regslave #(
   parameter int unsigned BYTE_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_cs_n,
   input  logic              spi_sclk,
   input  logic              spi_mosi,
   output logic              spi_miso,
   output logic              spi_miso_oe,
   output logic              frame16,
   output logic [BYTE_W-1:0] reg_addr,
   output logic [BYTE_W-1:0] reg_wdata,
   output logic              reg_we,
   input  logic [BYTE_W-1:0] reg_rdata
);

   import spi_regslave_pkg::*;

   localparam int unsigned CNT_W = frame_cnt_w(BYTE_W);
   localparam int unsigned NPIN  = 3;
   localparam logic [NPIN-1:0] PIN_RST = 3'b001;

   initial begin
      assert_byte_w_min : assert (BYTE_W >= 4)
         else $error("BYTE_W must be at least 4");
   end

   logic [NPIN-1:0] pin_raw;
   logic [NPIN-1:0] pin_s;

   assign pin_raw = {spi_mosi, spi_sclk, spi_cs_n};

   for (genvar g = 0; g < NPIN; g++) begin : g_sync
      spi_pin_sync #(
         .STAGES  (SYNC_STAGES),
         .RST_VAL (PIN_RST[g])
      ) u_sync (
         .clk   (clk),
         .rst_n (rst_n),
         .din   (pin_raw[g]),
         .q     (pin_s[g])
      );
   end

   spi_frame_core #(
      .BYTE_W (BYTE_W),
      .CNT_W  (CNT_W)
   ) u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .cs_act  (~pin_s[0]),
      .sclk_s  (pin_s[1]),
      .sdi_s   (pin_s[2]),
      .rdata   (reg_rdata),
      .addr    (reg_addr),
      .wdata   (reg_wdata),
      .we      (reg_we),
      .frame16 (frame16),
      .sdo     (spi_miso),
      .sdo_oe  (spi_miso_oe)
   );

endmodule

// File: tb/test_spi_regslave.sv
module test_spi_regslave;

   localparam int CLK_PERIOD = 10;
   localparam int HP         = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs_n = 1'b1;
   logic       sclk = 1'b0;
   logic       sdi = 1'b0;
   logic       sdo, sdo_oe, frame16, reg_we;
   logic [7:0] reg_addr, reg_wdata, reg_rdata;

   logic [7:0] regs  [256];
   logic [7:0] model [256];
   logic [15:0] exp_q [$];
   logic        we_prev = 1'b0;

   int total = 0;
   int fails = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   assign reg_rdata = regs[reg_addr];

   spi_regslave i_spi_regslave (
      .clk         (clk),
      .rst_n       (rst_n),
      .spi_cs_n    (cs_n),
      .spi_sclk    (sclk),
      .spi_mosi    (sdi),
      .spi_miso    (sdo),
      .spi_miso_oe (sdo_oe),
      .frame16     (frame16),
      .reg_addr    (reg_addr),
      .reg_wdata   (reg_wdata),
      .reg_we      (reg_we),
      .reg_rdata   (reg_rdata)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Every-clock comparison of the strobe against the expected-write queue.
   always @(negedge clk) begin
      if (rst_n) begin
         if (reg_we) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R3 unexpected strobe", {reg_addr, reg_wdata}, 0);
            end else begin
               logic [15:0] e;
               e = exp_q.pop_front();
               chk({reg_addr, reg_wdata} == e, "R3 strobe addr/data", {reg_addr, reg_wdata}, e);
            end
            regs[reg_addr] = reg_wdata;
         end
         if (reg_we && we_prev) chk(1'b0, "R3 strobe longer than one cycle", 2, 1);
         we_prev = reg_we;
      end
   end

   task automatic xfer(input logic [39:0] frame, input int nbits);
      logic [7:0] ctrl, addr, dat, expv;
      bit         rd;
      ctrl = frame[39:32];
      addr = frame[31:24];
      dat  = frame[23:16];
      rd   = ctrl[7];
      if (!rd && nbits >= 24) begin
         exp_q.push_back({addr, dat});
         model[addr] = dat;
      end
      expv = model[addr];
      cs_n = 1'b0;
      repeat (HP) @(negedge clk);
      for (int i = 0; i < nbits; i++) begin
         sdi = frame[39-i];
         repeat (HP) @(negedge clk);
         if (rd && i >= 16 && i < 32) begin
            chk(sdo_oe == 1'b1, "R4 output enabled in data", sdo_oe, 1);
            if (i < 24) chk(sdo == expv[7-(i%8)], "R4 read bit", sdo, expv[7-(i%8)]);
            else        chk(sdo == expv[7-(i%8)], "R5 repeated read bit", sdo, expv[7-(i%8)]);
         end else begin
            chk(sdo_oe == 1'b0, "R9 output tri-stated", sdo_oe, 0);
         end
         sclk = 1'b1;
         repeat (HP) @(negedge clk);
         sclk = 1'b0;
      end
      repeat (HP) @(negedge clk);
      if (nbits >= 32) chk(sdo_oe == 1'b0, "R9 tri-stated after bit 32", sdo_oe, 0);
      cs_n = 1'b1;
      repeat (HP) @(negedge clk);
      chk(sdo_oe == 1'b0, "R9 tri-stated with select high", sdo_oe, 0);
      chk(exp_q.size() == 0, "R3 expected strobe seen", exp_q.size(), 0);
      chk(frame16 == (nbits >= 25), "R7 framing flag", frame16, nbits >= 25);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      total++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      for (int a = 0; a < 256; a++) begin
         regs[a]  = 8'(a) ^ 8'h5A;
         model[a] = 8'(a) ^ 8'h5A;
      end
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(sdo_oe == 1'b0, "R9 reset output enable", sdo_oe, 0);
      chk(reg_we == 1'b0, "R3 reset strobe", reg_we, 0);
      chk(frame16 == 1'b0, "R7 reset framing flag", frame16, 0);

      // R1: 3-byte write, MSB first
      xfer({8'h00, 8'h3C, 8'hA5, 16'h0000}, 24);
      chk(regs[8'h3C] == 8'hA5, "R1 write captured", regs[8'h3C], 8'hA5);

      // R4: 3-byte read back
      xfer({8'h80, 8'h3C, 8'h00, 16'h0000}, 24);

      // R2, R6: write with low control bits set, 4-byte framing, trailing byte dropped
      xfer({8'h7F, 8'h51, 8'h96, 8'h0F, 8'h00}, 32);
      chk(regs[8'h51] == 8'h96, "R6 trailing byte discarded", regs[8'h51], 8'h96);
      chk(regs[8'h7F] == model[8'h7F], "R2 low control bits ignored", regs[8'h7F], model[8'h7F]);

      // R5: 4-byte read, byte repeated
      xfer({8'h80, 8'h51, 8'h00, 16'h0000}, 32);

      // R8: cut-short write is cancelled, next frame aligned
      xfer({8'h00, 8'h3C, 8'hFF, 16'h0000}, 20);
      chk(regs[8'h3C] == 8'hA5, "R8 cancelled write", regs[8'h3C], 8'hA5);
      xfer({8'h80, 8'h3C, 8'h00, 16'h0000}, 24);

      // R10: bits past 32 ignored
      xfer({8'h00, 8'h77, 8'h3E, 8'hC1, 8'h99}, 40);
      chk(regs[8'h77] == 8'h3E, "R10 extra bits ignored", regs[8'h77], 8'h3E);

      // R2: read with every control bit set
      xfer({8'hFF, 8'h77, 8'h00, 16'h0000}, 24);
      chk(regs[8'hFF] == model[8'hFF], "R2 read causes no write", regs[8'hFF], model[8'hFF]);

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

endmodule